// File: doc/BRIEF.md
# MESI Snooping Line-State Controller

This block keeps the coherence state of every line of a small, fully associative private write-back cache that sits on a shared snooping bus. Each line is Invalid, Shared, Exclusive or Modified. The core presents one request at a time: a load, a store or an eviction, with a tag. The block answers in the same cycle with a hit. Otherwise it stalls the core, raises one bus request and holds it until the bus grants it and the response completes. When the stall ends, the core request is evaluated again and hits.

On the bus side, the block watches snooped load misses, store misses and upgrades from other caches. In the same cycle it reports whether it holds the line, whether it supplies the data, and whether a dirty line is copied back to memory. At the next clock edge it downgrades or invalidates its own copy. A load miss that no other cache answers fills Exclusive. A later store to that line becomes Modified without any bus traffic. When the array is full, a miss replaces a victim line, and a dirty victim is written back before the miss is issued. A monitor port reads the state held for any tag. Bus arbitration, memory and the data arrays live outside the block.

Top module: `mesi_snoop_ctrl`

## Requirements
- R1: After reset every line is Invalid: `mon_state` reads 0 for any tag, `bus_req_valid` is low, and no snoop output is raised. States encode as I=0, S=1, E=2, M=3.
- R2: A load (`core_op`=0) to a line held in S, E or M raises `core_hit` in the same cycle, with no bus request.
- R3: A load to an absent tag stalls the core and requests a load miss (`bus_req_kind`=0) for that tag. The request completes one clock edge after the cycle in which `bus_resp_done` is high. The line then fills to E if `bus_resp_shared` was low in that cycle, and to S otherwise. The replayed load hits in the next cycle.
- R4: A store (`core_op`=1) to an absent tag requests a store miss (`bus_req_kind`=1), and the line becomes M.
- R5: A store to a line in S requests an upgrade (`bus_req_kind`=2), and the line becomes M. If a remote store miss invalidates the line before the grant, the pending request turns into a store miss.
- R6: A store to a line in E hits in the same cycle, raises no bus request, and leaves the line in M.
- R7: A snooped load miss (`snp_kind`=0) to a held line raises `snp_has_copy`. In E or M it also raises `snp_supply`, and the line moves to S. In M it additionally raises `snp_mem_update`.
- R8: A snooped store miss (`snp_kind`=1) or upgrade (`snp_kind`=2) to a held line makes the line Invalid. `snp_supply` is raised only when the line was M.
- R9: Evicting (`core_op`=2) a line in M requests a writeback (`bus_req_kind`=3) and then leaves the line Invalid. Evicting a clean line invalidates it silently with a same-cycle hit. Evicting an absent tag is a hit with no effect.
- R10: A miss goes to the lowest-numbered Invalid line. When all lines are valid, it goes to a round-robin victim that advances on every fill. A Modified victim is written back before the miss request. No two valid lines ever hold the same tag.
- R11: A load or store request stays raised, with an unchanged tag, until `bus_grant`. A writeback request is withdrawn if a snoop has already taken the line out of M.
- R12: A snoop with `snp_kind`=3, or one whose tag is not held, raises no snoop output and changes no line.
- R13: When a core request and an active snoop hit the same line in the same cycle, the snoop is applied and the core is stalled for that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| core_valid | input | 1 | Core request present |
| core_op | input | 2 | 0 load, 1 store, 2 evict |
| core_tag | input | TAG_W | Tag of the core request |
| core_hit | output | 1 | Request completes this cycle |
| core_stall | output | 1 | Request present and not completing |
| bus_req_valid | output | 1 | Bus request raised |
| bus_req_kind | output | 2 | 0 load miss, 1 store miss, 2 upgrade, 3 writeback |
| bus_req_tag | output | TAG_W | Tag of the bus request |
| bus_grant | input | 1 | Bus accepts the raised request |
| bus_resp_done | input | 1 | Response of the granted request completes |
| bus_resp_shared | input | 1 | Another cache holds the line (with `bus_resp_done`) |
| snp_valid | input | 1 | Snooped remote request present |
| snp_kind | input | 2 | Same encoding as `bus_req_kind` |
| snp_tag | input | TAG_W | Tag of the snooped request |
| snp_supply | output | 1 | This cache supplies the line data |
| snp_mem_update | output | 1 | Supplied dirty data also updates memory |
| snp_has_copy | output | 1 | A remote load miss finds the line here |
| mon_tag | input | TAG_W | Tag whose state is read |
| mon_state | output | 2 | State held for `mon_tag` |

## Verification
The bench builds the block with four lines and eight-bit tags. With four lines, a handful of stores fills the whole array, so the full-array path can be reached quickly: victim replacement, the round-robin pointer after several fills, and a dirty victim's writeback ahead of the miss. The bus responder's grant delay can be changed. Stretching it opens a window in which a remote store miss arrives while an upgrade is still pending, and lets the bench see that requests are held until granted.

// File: rtl/mesi_pkg.sv
// Shared encodings for the MESI line-state controller.
// Assumes two-bit codes on every port that carries a state, an operation or a bus kind.
package mesi_pkg;

    typedef enum logic [1:0] {
        ST_I = 2'd0,
        ST_S = 2'd1,
        ST_E = 2'd2,
        ST_M = 2'd3
    } line_st_t;

    typedef enum logic [1:0] {
        BK_LDMISS = 2'd0,
        BK_STMISS = 2'd1,
        BK_UPGRADE = 2'd2,
        BK_WRBACK = 2'd3
    } bus_kind_t;

    typedef enum logic [1:0] {
        OP_LOAD  = 2'd0,
        OP_STORE = 2'd1,
        OP_EVICT = 2'd2
    } core_op_t;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_REQ  = 2'd1,
        PH_RESP = 2'd2
    } phase_t;

    typedef enum logic [1:0] {
        PD_LOAD  = 2'd0,
        PD_STORE = 2'd1,
        PD_WB    = 2'd2
    } pend_t;

endpackage

// File: rtl/mesi_tag_match.sv
// Fully associative tag lookup: compares a key against every valid line.
// Assumes at most one line matches; reports the lowest matching index otherwise.
module mesi_tag_match #(
    parameter int N_LINES = 4,
    parameter int TW      = 8,
    localparam int IW     = (N_LINES > 1) ? $clog2(N_LINES) : 1
) (
    input  logic [N_LINES*TW-1:0] tags_flat,
    input  logic [N_LINES-1:0]    line_vld,
    input  logic [TW-1:0]         key,
    output logic                  hit,
    output logic [IW-1:0]         idx,
    output logic [N_LINES-1:0]    match
);

    // One comparator per line.
    for (genvar g = 0; g < N_LINES; g++) begin : g_cmp
        assign match[g] = line_vld[g] && (tags_flat[g*TW +: TW] == key);
    end

    // Priority-encode the match vector.
    always_comb begin
        idx = '0;
        for (int i = N_LINES - 1; i >= 0; i--) begin
            if (match[i]) idx = IW'(i);
        end
    end

    assign hit = |match;

endmodule

// File: rtl/mesi_victim_pick.sv
// Chooses the line that a miss fills: lowest Invalid line, else the round-robin pointer.
// Assumes the pointer is kept below N_LINES by its owner.
module mesi_victim_pick #(
    parameter int N_LINES = 4,
    localparam int IW     = (N_LINES > 1) ? $clog2(N_LINES) : 1
) (
    input  logic [N_LINES-1:0] line_vld,
    input  logic [IW-1:0]      rr_ptr,
    output logic [IW-1:0]      victim
);

    // Scan from the top so the lowest free line wins.
    always_comb begin
        victim = rr_ptr;
        for (int i = N_LINES - 1; i >= 0; i--) begin
            if (!line_vld[i]) victim = IW'(i);
        end
    end

endmodule

// File: rtl/mesi_snoop_ctrl.sv
// MESI coherence controller for a small fully associative write-back cache.
// Keeps one state and tag per line, serves one core request at a time, and raises one bus
// request at a time. Applies snoops in the cycle they arrive.
// Assumes the bus delivers no snoop for the tag of a granted request before its response.
module mesi_snoop_ctrl
    import mesi_pkg::*;
#(
    parameter int NUM_LINES = 4,
    parameter int TAG_W     = 8,
    localparam int IW       = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             core_valid,
    input  logic [1:0]       core_op,
    input  logic [TAG_W-1:0] core_tag,
    output logic             core_hit,
    output logic             core_stall,
    output logic             bus_req_valid,
    output logic [1:0]       bus_req_kind,
    output logic [TAG_W-1:0] bus_req_tag,
    input  logic             bus_grant,
    input  logic             bus_resp_done,
    input  logic             bus_resp_shared,
    input  logic             snp_valid,
    input  logic [1:0]       snp_kind,
    input  logic [TAG_W-1:0] snp_tag,
    output logic             snp_supply,
    output logic             snp_mem_update,
    output logic             snp_has_copy,
    input  logic [TAG_W-1:0] mon_tag,
    output logic [1:0]       mon_state
);

    line_st_t             st_q  [NUM_LINES];
    logic [TAG_W-1:0]     tag_q [NUM_LINES];
    logic [NUM_LINES*TAG_W-1:0] tags_flat;
    logic [NUM_LINES-1:0] line_vld;

    phase_t               phase_q;
    pend_t                pend_q;
    logic [IW-1:0]        pidx_q;
    logic [TAG_W-1:0]     ptag_q;
    bus_kind_t            gkind_q;
    logic [IW-1:0]        rr_q;

    // Flatten the tag array for the lookups.
    for (genvar g = 0; g < NUM_LINES; g++) begin : g_flat
        assign tags_flat[g*TAG_W +: TAG_W] = tag_q[g];
        assign line_vld[g] = (st_q[g] != ST_I);
    end

    logic                 c_hit, s_hit, m_hit;
    logic [IW-1:0]        c_idx, s_idx, m_idx, v_idx;
    logic [NUM_LINES-1:0] c_match, s_match, m_match;

    mesi_tag_match #(.N_LINES(NUM_LINES), .TW(TAG_W)) u_core_lu (
        .tags_flat(tags_flat), .line_vld(line_vld), .key(core_tag),
        .hit(c_hit), .idx(c_idx), .match(c_match));

    mesi_tag_match #(.N_LINES(NUM_LINES), .TW(TAG_W)) u_snp_lu (
        .tags_flat(tags_flat), .line_vld(line_vld), .key(snp_tag),
        .hit(s_hit), .idx(s_idx), .match(s_match));

    mesi_tag_match #(.N_LINES(NUM_LINES), .TW(TAG_W)) u_mon_lu (
        .tags_flat(tags_flat), .line_vld(line_vld), .key(mon_tag),
        .hit(m_hit), .idx(m_idx), .match(m_match));

    mesi_victim_pick #(.N_LINES(NUM_LINES)) u_victim (
        .line_vld(line_vld), .rr_ptr(rr_q), .victim(v_idx));

    // Snoop side: decide the response from the line's current state.
    line_st_t s_st;
    logic     snp_act, snp_is_ld;
    assign s_st      = st_q[s_idx];
    assign snp_act   = snp_valid && (snp_kind != BK_WRBACK) && s_hit;
    assign snp_is_ld = (snp_kind == BK_LDMISS);

    assign snp_has_copy   = snp_act && snp_is_ld;
    assign snp_supply     = snp_act && (snp_is_ld ? (s_st == ST_M || s_st == ST_E) : (s_st == ST_M));
    assign snp_mem_update = snp_act && snp_is_ld && (s_st == ST_M);

    assign mon_state = m_hit ? st_q[m_idx] : ST_I;

    // Core side: decide whether the request completes without the bus.
    line_st_t c_st;
    logic     collide, core_ok, start;
    assign c_st    = st_q[c_idx];
    assign collide = snp_act && c_hit && (s_idx == c_idx);

    // Classify the request against the line state.
    always_comb begin
        case (core_op)
            OP_LOAD:  core_ok = c_hit;
            OP_STORE: core_ok = c_hit && (c_st == ST_E || c_st == ST_M);
            default:  core_ok = !c_hit || (c_st != ST_M);
        endcase
    end

    assign core_hit   = (phase_q == PH_IDLE) && core_valid && !collide && core_ok;
    assign core_stall = core_valid && !core_hit;
    assign start      = (phase_q == PH_IDLE) && core_valid && !collide && !core_ok;

    // Bus request: the kind follows the pending line's present state.
    line_st_t  p_st;
    logic [TAG_W-1:0] p_tag;
    logic      req_cancel;
    bus_kind_t req_kind;
    assign p_st  = st_q[pidx_q];
    assign p_tag = tag_q[pidx_q];

    // Pick the bus request for the pending operation.
    always_comb begin
        req_cancel  = 1'b0;
        req_kind    = BK_LDMISS;
        bus_req_tag = ptag_q;
        case (pend_q)
            PD_WB: begin
                req_kind    = BK_WRBACK;
                bus_req_tag = p_tag;
                req_cancel  = (p_st != ST_M);
            end
            PD_STORE: req_kind = (p_st == ST_S && p_tag == ptag_q) ? BK_UPGRADE : BK_STMISS;
            default:  req_kind = BK_LDMISS;
        endcase
    end

    assign bus_req_valid = (phase_q == PH_REQ) && !req_cancel;
    assign bus_req_kind  = req_kind;

    // State, tag and transaction registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_LINES; i++) begin
                st_q[i]  <= ST_I;
                tag_q[i] <= '0;
            end
            phase_q <= PH_IDLE;
            pend_q  <= PD_LOAD;
            pidx_q  <= '0;
            ptag_q  <= '0;
            gkind_q <= BK_LDMISS;
            rr_q    <= '0;
        end else begin
            if (snp_act) begin
                if (snp_is_ld) begin
                    if (s_st == ST_M || s_st == ST_E) st_q[s_idx] <= ST_S;
                end else begin
                    st_q[s_idx] <= ST_I;
                end
            end
            case (phase_q)
                PH_IDLE: begin
                    if (core_hit) begin
                        if (core_op == OP_STORE && c_st == ST_E) st_q[c_idx] <= ST_M;
                        if (core_op[1] && c_hit && c_st != ST_M) st_q[c_idx] <= ST_I;
                    end else if (start) begin
                        phase_q <= PH_REQ;
                        ptag_q  <= core_tag;
                        if (core_op[1]) begin
                            pend_q <= PD_WB;
                            pidx_q <= c_idx;
                        end else if (c_hit) begin
                            pend_q <= PD_STORE;
                            pidx_q <= c_idx;
                        end else begin
                            pidx_q <= v_idx;
                            if (st_q[v_idx] == ST_M) pend_q <= PD_WB;
                            else pend_q <= (core_op == OP_STORE) ? PD_STORE : PD_LOAD;
                        end
                    end
                end
                PH_REQ: begin
                    if (req_cancel) begin
                        phase_q <= PH_IDLE;
                    end else if (bus_grant) begin
                        phase_q <= PH_RESP;
                        gkind_q <= req_kind;
                    end
                end
                default: begin
                    if (bus_resp_done) begin
                        phase_q <= PH_IDLE;
                        if (gkind_q == BK_WRBACK) begin
                            st_q[pidx_q] <= ST_I;
                        end else begin
                            tag_q[pidx_q] <= ptag_q;
                            if (gkind_q == BK_LDMISS) st_q[pidx_q] <= bus_resp_shared ? ST_S : ST_E;
                            else st_q[pidx_q] <= ST_M;
                            rr_q <= (rr_q == IW'(NUM_LINES - 1)) ? '0 : rr_q + 1'b1;
                        end
                    end
                end
            endcase
        end
    end

    logic resp_fill;
    assign resp_fill = (phase_q == PH_RESP) && bus_resp_done && (gkind_q != BK_WRBACK);

    // R10: no tag is ever held twice.
    p_unique_tag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(c_match) && $onehot0(s_match) && $onehot0(m_match));

    // R6: a store hit leaves the line Modified.
    p_store_hit_m_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (core_hit && core_op == OP_STORE) |=> (st_q[$past(c_idx)] == ST_M));

    // R7: an owned line answering a remote load miss becomes Shared.
    p_ld_snoop_share_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_act && snp_is_ld && (s_st == ST_M || s_st == ST_E) && !(resp_fill && pidx_q == s_idx))
        |=> (st_q[$past(s_idx)] == ST_S));

    // R8: a remote store miss or upgrade invalidates the held line.
    p_remote_inval_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_act && !snp_is_ld && !(resp_fill && pidx_q == s_idx))
        |=> (st_q[$past(s_idx)] == ST_I));

    // R3: a load-miss fill follows the shared response.
    p_fill_state_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_RESP && bus_resp_done && gkind_q == BK_LDMISS)
        |=> (st_q[$past(pidx_q)] == ($past(bus_resp_shared) ? ST_S : ST_E)));

    // R11: a fill request is held until granted.
    p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_valid && !bus_grant && pend_q != PD_WB) |=> (bus_req_valid && $stable(bus_req_tag)));

endmodule

// File: tb/mesi_snoop_ctrl_tb.sv
module mesi_snoop_ctrl_tb;

    localparam int N  = 4;
    localparam int TW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic core_valid = 1'b0;
    logic [1:0] core_op = '0;
    logic [TW-1:0] core_tag = '0;
    logic core_hit, core_stall, bus_req_valid;
    logic [1:0] bus_req_kind;
    logic [TW-1:0] bus_req_tag;
    logic bus_grant = 1'b0, bus_resp_done = 1'b0, bus_resp_shared = 1'b0;
    logic snp_valid = 1'b0;
    logic [1:0] snp_kind = '0;
    logic [TW-1:0] snp_tag = '0;
    logic snp_supply, snp_mem_update, snp_has_copy;
    logic [TW-1:0] mon_tag = '0;
    logic [1:0] mon_state;

    always #5 clk = ~clk;

    mesi_snoop_ctrl #(.NUM_LINES(N), .TAG_W(TW)) u_dut (
        .clk(clk), .rst_n(rst_n), .core_valid(core_valid), .core_op(core_op), .core_tag(core_tag),
        .core_hit(core_hit), .core_stall(core_stall), .bus_req_valid(bus_req_valid),
        .bus_req_kind(bus_req_kind), .bus_req_tag(bus_req_tag), .bus_grant(bus_grant),
        .bus_resp_done(bus_resp_done), .bus_resp_shared(bus_resp_shared), .snp_valid(snp_valid),
        .snp_kind(snp_kind), .snp_tag(snp_tag), .snp_supply(snp_supply),
        .snp_mem_update(snp_mem_update), .snp_has_copy(snp_has_copy), .mon_tag(mon_tag),
        .mon_state(mon_state));

    int checks = 0;
    int failures = 0;
    string scen = "R1";

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int mt[N];
    int ms[N];
    int mph, mpop, midx, mptag, mgk, mrr;
    int e_hit, e_stall, e_breq, e_bkind, e_btag, e_sup, e_mem, e_copy, e_mon;
    int e_sidx, e_cidx, e_collide, e_cancel;

    function automatic int mfind(int tag);
        for (int i = 0; i < N; i++) if (ms[i] != 0 && mt[i] == tag) return i;
        return -1;
    endfunction

    function automatic void meval();
        int ok, s, mi;
        e_sidx = -1;
        if (snp_valid && snp_kind != 3) e_sidx = mfind(int'(snp_tag));
        e_sup = 0; e_mem = 0; e_copy = 0;
        if (e_sidx >= 0) begin
            s = ms[e_sidx];
            if (snp_kind == 0) begin
                e_copy = 1; e_sup = (s >= 2); e_mem = (s == 3);
            end else e_sup = (s == 3);
        end
        mi = mfind(int'(mon_tag));
        e_mon = (mi >= 0) ? ms[mi] : 0;
        e_cidx = mfind(int'(core_tag));
        e_collide = (e_sidx >= 0) && (e_cidx == e_sidx);
        if (core_op == 0) ok = (e_cidx >= 0);
        else if (core_op == 1) ok = (e_cidx >= 0) && (ms[e_cidx] >= 2);
        else ok = (e_cidx < 0) || (ms[e_cidx] != 3);
        e_hit = (mph == 0) && core_valid && !e_collide && ok;
        e_stall = core_valid && !e_hit;
        e_breq = 0; e_cancel = 0; e_bkind = 0; e_btag = 0;
        if (mph == 1) begin
            if (mpop == 2) begin
                if (ms[midx] == 3) begin e_breq = 1; e_bkind = 3; e_btag = mt[midx]; end
                else e_cancel = 1;
            end else if (mpop == 0) begin
                e_breq = 1; e_bkind = 0; e_btag = mptag;
            end else begin
                e_breq = 1; e_btag = mptag;
                e_bkind = (ms[midx] == 1 && mt[midx] == mptag) ? 2 : 1;
            end
        end
    endfunction

    // Model update on each edge, from the inputs the design sees.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin mt[i] = 0; ms[i] = 0; end
            mph = 0; mpop = 0; midx = 0; mptag = 0; mgk = 0; mrr = 0;
        end else begin
            int v, vst, cst;
            meval();
            v = -1;
            for (int i = 0; i < N; i++) if (ms[i] == 0 && v < 0) v = i;
            if (v < 0) v = mrr;
            vst = ms[v];
            cst = (e_cidx >= 0) ? ms[e_cidx] : 0;
            if (e_sidx >= 0) begin
                if (snp_kind == 0) begin if (ms[e_sidx] >= 2) ms[e_sidx] = 1; end
                else ms[e_sidx] = 0;
            end
            if (mph == 0) begin
                if (core_valid && !e_collide) begin
                    if (e_hit) begin
                        if (core_op == 1 && cst == 2) ms[e_cidx] = 3;
                        if (core_op >= 2 && e_cidx >= 0 && cst != 3) ms[e_cidx] = 0;
                    end else begin
                        mph = 1; mptag = int'(core_tag);
                        if (core_op >= 2) begin mpop = 2; midx = e_cidx; end
                        else if (e_cidx >= 0) begin mpop = 1; midx = e_cidx; end
                        else begin midx = v; mpop = (vst == 3) ? 2 : int'(core_op); end
                    end
                end
            end else if (mph == 1) begin
                if (e_cancel) mph = 0;
                else if (bus_grant) begin mph = 2; mgk = e_bkind; end
            end else if (bus_resp_done) begin
                mph = 0;
                if (mgk == 3) ms[midx] = 0;
                else begin
                    mt[midx] = mptag;
                    ms[midx] = (mgk == 0) ? (bus_resp_shared ? 1 : 2) : 3;
                    mrr = (mrr + 1) % N;
                end
            end
        end
    end

    // Compare every cycle, away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            int bad;
            meval();
            bad = (int'(core_hit) != e_hit) || (int'(core_stall) != e_stall) ||
                  (int'(bus_req_valid) != e_breq) ||
                  (e_breq && (int'(bus_req_kind) != e_bkind || int'(bus_req_tag) != e_btag)) ||
                  (int'(snp_supply) != e_sup) || (int'(snp_mem_update) != e_mem) ||
                  (int'(snp_has_copy) != e_copy) || (int'(mon_state) != e_mon);
            checks++;
            if (bad) begin
                failures++;
                $display("FAIL %s cycle model: actual hit=%0d stall=%0d req=%0d kind=%0d tag=%0d sup=%0d mem=%0d copy=%0d mon=%0d expected hit=%0d stall=%0d req=%0d kind=%0d tag=%0d sup=%0d mem=%0d copy=%0d mon=%0d",
                    scen, core_hit, core_stall, bus_req_valid, bus_req_kind, bus_req_tag, snp_supply,
                    snp_mem_update, snp_has_copy, mon_state, e_hit, e_stall, e_breq, e_bkind, e_btag,
                    e_sup, e_mem, e_copy, e_mon);
            end
        end
    end

    // ---------------- bus responder ----------------
    int gdly = 0, rdly = 0, a_shared = 0, a_ph = 0, a_cnt = 0;

    always @(posedge clk) begin
        #1;
        bus_grant = 1'b0;
        bus_resp_done = 1'b0;
        bus_resp_shared = 1'b0;
        if (rst_n) begin
            if (a_ph == 0) begin
                if (bus_req_valid) begin
                    if (a_cnt >= gdly) begin bus_grant = 1'b1; a_ph = 1; a_cnt = 0; end
                    else a_cnt++;
                end else a_cnt = 0;
            end else begin
                if (a_cnt >= rdly) begin
                    bus_resp_done = 1'b1; bus_resp_shared = a_shared[0]; a_ph = 0; a_cnt = 0;
                end else a_cnt++;
            end
        end
    end

    // ---------------- stimulus tasks ----------------
    int r_cycles, r_first, r_last, r_hit1, r_reqcyc;
    int s_sup, s_mem, s_copy;

    task automatic core_do(int op, int tag);
        @(posedge clk); #1;
        core_valid = 1'b1; core_op = op[1:0]; core_tag = tag[TW-1:0];
        r_cycles = 0; r_first = -1; r_last = -1; r_hit1 = -1; r_reqcyc = 0;
        forever begin
            @(negedge clk);
            r_cycles++;
            if (r_hit1 < 0) r_hit1 = int'(core_hit);
            if (bus_req_valid) begin
                if (r_first < 0) r_first = int'(bus_req_kind);
                r_last = int'(bus_req_kind);
                r_reqcyc++;
            end
            if (core_hit || r_cycles > 60) break;
        end
        @(posedge clk); #1;
        core_valid = 1'b0;
    endtask

    task automatic snoop_do(int kind, int tag);
        @(posedge clk); #1;
        snp_valid = 1'b1; snp_kind = kind[1:0]; snp_tag = tag[TW-1:0];
        @(negedge clk);
        s_sup = int'(snp_supply); s_mem = int'(snp_mem_update); s_copy = int'(snp_has_copy);
        @(posedge clk); #1;
        snp_valid = 1'b0;
    endtask

    task automatic state_of(int tag, output int st);
        @(posedge clk); #1;
        mon_tag = tag[TW-1:0];
        @(negedge clk);
        st = int'(mon_state);
    endtask

    // Watchdog: a hung run is a failed check.
    int wd = 0;
    always @(posedge clk) begin
        wd++;
        if (wd > 50000) begin
            checks++; failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", wd, 50000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int st, cnt;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state.
        scen = "R1";
        state_of(8'h11, st);
        check("R1 state after reset", st, 0);
        check("R1 no bus request", int'(bus_req_valid), 0);
        check("R1 no supply", int'(snp_supply), 0);

        // R3: load miss, no sharer, fills E.
        scen = "R3"; a_shared = 0; gdly = 1; rdly = 1;
        core_do(0, 8'h11);
        check("R3 load miss kind", r_first, 0);
        check("R3 load stalls", (r_cycles > 1) ? 1 : 0, 1);
        state_of(8'h11, st);
        check("R3 fill to E", st, 2);

        // R2: load hit.
        scen = "R2";
        core_do(0, 8'h11);
        check("R2 load hit same cycle", r_cycles, 1);
        check("R2 no bus on hit", r_first, -1);

        // R6: store to E is silent.
        scen = "R6";
        core_do(1, 8'h11);
        check("R6 store hit same cycle", r_cycles, 1);
        check("R6 no bus on E store", r_first, -1);
        state_of(8'h11, st);
        check("R6 E to M", st, 3);

        // R7: remote load miss on M.
        scen = "R7";
        snoop_do(0, 8'h11);
        check("R7 supply from M", s_sup, 1);
        check("R7 memory update from M", s_mem, 1);
        check("R7 has copy", s_copy, 1);
        state_of(8'h11, st);
        check("R7 M to S", st, 1);

        // R5: store to S upgrades.
        scen = "R5";
        core_do(1, 8'h11);
        check("R5 upgrade kind", r_first, 2);
        state_of(8'h11, st);
        check("R5 S to M", st, 3);

        // R8: remote store miss on M.
        scen = "R8";
        snoop_do(1, 8'h11);
        check("R8 supply from M", s_sup, 1);
        state_of(8'h11, st);
        check("R8 M to I", st, 0);

        // R3 shared fill, then R8 upgrade snoop on S.
        scen = "R3"; a_shared = 1;
        core_do(0, 8'h22);
        state_of(8'h22, st);
        check("R3 fill to S when shared", st, 1);
        a_shared = 0;
        scen = "R8";
        snoop_do(2, 8'h22);
        check("R8 no supply from S", s_sup, 0);
        state_of(8'h22, st);
        check("R8 upgrade snoop invalidates", st, 0);

        // R4: store miss.
        scen = "R4";
        core_do(1, 8'h33);
        check("R4 store miss kind", r_first, 1);
        state_of(8'h33, st);
        check("R4 I to M", st, 3);

        // R12: ignored snoops.
        scen = "R12";
        snoop_do(3, 8'h33);
        check("R12 writeback snoop no supply", s_sup, 0);
        snoop_do(1, 8'h77);
        check("R12 absent tag no supply", s_sup + s_copy, 0);
        state_of(8'h33, st);
        check("R12 line unchanged", st, 3);

        // R9: evictions.
        scen = "R9";
        core_do(2, 8'h33);
        check("R9 writeback kind", r_first, 3);
        state_of(8'h33, st);
        check("R9 M evicted to I", st, 0);
        core_do(0, 8'h44);
        core_do(2, 8'h44);
        check("R9 clean evict silent", r_cycles, 1);
        check("R9 clean evict no bus", r_first, -1);
        state_of(8'h44, st);
        check("R9 clean evict to I", st, 0);
        core_do(2, 8'h99);
        check("R9 absent evict hits", r_cycles, 1);

        // R5 race: remote store miss before grant turns upgrade into store miss.
        scen = "R5"; a_shared = 1;
        core_do(0, 8'h55);
        a_shared = 0; gdly = 5;
        fork
            core_do(1, 8'h55);
            begin repeat (2) @(posedge clk); snoop_do(1, 8'h55); end
        join
        check("R5 request began as upgrade", r_first, 2);
        check("R5 request became store miss", r_last, 1);
        state_of(8'h55, st);
        check("R5 race ends in M", st, 3);

        // R11: request held across a long grant delay.
        scen = "R11"; gdly = 4;
        core_do(0, 8'h66);
        check("R11 request held until grant", (r_reqcyc >= 5) ? 1 : 0, 1);
        gdly = 1;

        // R13: collision of core store and snoop on an E line.
        scen = "R13";
        core_do(2, 8'h66);
        core_do(0, 8'h66);
        fork
            core_do(1, 8'h66);
            snoop_do(0, 8'h66);
        join
        check("R13 core stalled on collision", r_hit1, 0);
        check("R13 snoop served from E", s_sup, 1);
        check("R13 store then upgrades", r_first, 2);

        // R10: fill the array with dirty lines, then miss once more.
        scen = "R10";
        core_do(2, 8'h55);
        core_do(2, 8'h66);
        for (int t = 0; t < N; t++) core_do(1, 8'h40 + t);
        core_do(0, 8'h50);
        check("R10 dirty victim written back first", r_first, 3);
        check("R10 then load miss", r_last, 0);
        cnt = 0;
        for (int t = 0; t < N; t++) begin
            state_of(8'h40 + t, st);
            if (st == 3) cnt++;
        end
        check("R10 exactly one line replaced", cnt, N - 1);
        state_of(8'h50, st);
        check("R10 new line filled E", st, 2);
        core_do(1, 8'h60);
        check("R10 second victim written back", r_first, 3);

        repeat (3) @(posedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule